// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the 16x-oversampling clock-enable pulse for a UART from the system clock. The division ratio is the system clock frequency over sixteen times the baud rate, held as a 16-bit whole part and a 6-bit fraction in 1/64 steps. Software rounds the fraction as the remainder times 64 plus one half, truncated. For example, a 20 MHz clock at 115200 baud gives a whole part of 10 and a fraction of 54. The fraction is realised by dithering: each output period lasts either N or N+1 clocks. The choice is set by the carry out of a 6-bit accumulator that adds the fraction once per period. Over 64 periods the average is therefore exactly N + F/64 clocks.

Divisor writes go into staging registers. They take effect only when the line-control write strobe commits them, and the commit also clears the accumulator. The control state machine has three states. GEN_OFF is idle and is the only state in which writes are accepted. GEN_RUN produces ticks. GEN_DRAIN keeps ticking after the enable has dropped, until the serial logic's busy input falls.

The transitions are as follows:
- GEN_OFF to GEN_RUN when the enable is high.
- GEN_RUN to GEN_OFF when the enable is low and busy is low.
- GEN_RUN to GEN_DRAIN when the enable is low and busy is high.
- GEN_DRAIN to GEN_RUN when the enable returns.
- GEN_DRAIN to GEN_OFF when the enable is low and busy is low.

Top module: `uart_frac_baud_gen`

## Requirements
- R1: After reset the generator is in GEN_OFF, the tick output is low, and the period counter and accumulator are zero; no tick appears until the enable is raised.
- R2: With fraction 0 and whole part N > 1, the tick is a one-cycle pulse repeating every N clocks while running.
- R3: With fraction F, period k after a commit or enable lasts N clocks plus the carry out of the 6-bit sum produced at the end of period k-1. The accumulator starts from 0, so the first period is N.
- R4: With N = 10 and F = 54, any 64 consecutive intervals starting from a cleared accumulator sum to 694 clocks.
- R5: Writes to the whole or fractional divisor do not change the tick period until a line-control write strobe commits them. Committing, and also entering GEN_OFF, clears the accumulator.
- R6: Divisor and line-control writes made in GEN_RUN or GEN_DRAIN are discarded. They alter neither the active nor the staged divisor.
- R7: An active whole part of 0 is invalid, and no tick is produced while it is active.
- R8: Dropping the enable while busy is low moves to GEN_OFF on the next clock, and ticks stop.
- R9: Dropping the enable while busy is high moves to GEN_DRAIN. Ticks continue at the same rate until busy is sampled low, then the generator enters GEN_OFF and ticks stop.
- R10: Raising the enable again during GEN_DRAIN returns to GEN_RUN, and ticks continue after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_int_wr | input | 1 | Write strobe for the staged whole-part divisor |
| div_int_data | input | 16 | Whole-part divisor value |
| div_frac_wr | input | 1 | Write strobe for the staged fractional divisor |
| div_frac_data | input | 6 | Fractional divisor in 1/64 units |
| line_ctl_wr | input | 1 | Line-control write strobe; commits the staged divisor |
| uart_en | input | 1 | UART enable |
| busy | input | 1 | A character is in progress in the transmitter or receiver |
| tick | output | 1 | One-cycle 16x baud enable pulse |

## Verification
Every cycle, the assertions check four things. A tick appears only outside GEN_OFF and never while the whole part is zero. The active divisor stays unchanged while the generator is not idle. The drain entry and exit transitions follow the enable and busy inputs. The exact dithered period sequence and its 64-period average can only be shown by the bench's scoreboard, which compares measured tick intervals against an independent accumulator model. The bench scenarios also show that staged writes stay inert until a commit, that writes made while running are lost, and that ticks stop only after busy falls.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    typedef enum logic [1:0] {
        GEN_OFF   = 2'd0,
        GEN_RUN   = 2'd1,
        GEN_DRAIN = 2'd2
    } gen_state_t;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_allow,
    input  logic              int_wr,
    input  logic [INT_W-1:0]  int_data,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_data,
    input  logic              commit_wr,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic              commit
);
    logic [INT_W-1:0]  stage_int;
    logic [FRAC_W-1:0] stage_frac;

    assign commit = commit_wr && wr_allow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_int  <= '0;
            stage_frac <= '0;
        end else if (wr_allow) begin
            if (int_wr)  stage_int  <= int_data;
            if (frac_wr) stage_frac <= frac_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_int  <= '0;
            act_frac <= '0;
        end else if (commit) begin
            act_int  <= stage_int;
            act_frac <= stage_frac;
        end
    end
endmodule

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
    import baud_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uart_en,
    input  logic       busy,
    output gen_state_t state,
    output logic       run,
    output logic       wr_allow
);
    gen_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GEN_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            GEN_OFF:   if (uart_en) nxt = GEN_RUN;
            GEN_RUN:   if (!uart_en) nxt = busy ? GEN_DRAIN : GEN_OFF;
            GEN_DRAIN: begin
                if (uart_en)    nxt = GEN_RUN;
                else if (!busy) nxt = GEN_OFF;
            end
            default:   nxt = GEN_OFF;
        endcase
    end

    always_comb begin
        run      = 1'b0;
        wr_allow = 1'b0;
        unique case (state)
            GEN_OFF:   wr_allow = 1'b1;
            GEN_RUN:   run      = 1'b1;
            GEN_DRAIN: run      = 1'b1;
            default:   wr_allow = 1'b1;
        endcase
    end
endmodule

// File: rtl/baud_frac_divider.sv
module baud_frac_divider #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    localparam int CNT_W = INT_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  len;
    logic [FRAC_W-1:0] acc;
    logic              ext;
    logic              valid;
    logic              at_end;
    logic [FRAC_W:0]   sum;

    assign valid  = (div_int != '0);
    assign len    = {1'b0, div_int} + CNT_W'(ext);
    assign at_end = (cnt == len - CNT_W'(1));
    assign sum    = {1'b0, acc} + {1'b0, div_frac};
    assign tick   = run && valid && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
            ext <= 1'b0;
        end else if (clear) begin
            cnt <= '0;
            acc <= '0;
            ext <= 1'b0;
        end else if (run && valid) begin
            if (at_end) begin
                cnt <= '0;
                acc <= sum[FRAC_W-1:0];
                ext <= sum[FRAC_W];
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/uart_frac_baud_gen.sv
module uart_frac_baud_gen
    import baud_gen_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_int_wr,
    input  logic [INT_W-1:0]  div_int_data,
    input  logic              div_frac_wr,
    input  logic [FRAC_W-1:0] div_frac_data,
    input  logic              line_ctl_wr,
    input  logic              uart_en,
    input  logic              busy,
    output logic              tick
);
    gen_state_t        st;
    logic              run;
    logic              wr_allow;
    logic              commit;
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;

    baud_gen_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .uart_en  (uart_en),
        .busy     (busy),
        .state    (st),
        .run      (run),
        .wr_allow (wr_allow)
    );

    baud_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_allow  (wr_allow),
        .int_wr    (div_int_wr),
        .int_data  (div_int_data),
        .frac_wr   (div_frac_wr),
        .frac_data (div_frac_data),
        .commit_wr (line_ctl_wr),
        .act_int   (act_int),
        .act_frac  (act_frac),
        .commit    (commit)
    );

    baud_frac_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clear    (commit || !run),
        .div_int  (act_int),
        .div_frac (act_frac),
        .tick     (tick)
    );
endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker
    import baud_gen_pkg::*;
#(
    parameter int INT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             uart_en,
    input logic             busy,
    input logic             tick,
    input gen_state_t       st,
    input logic [INT_W-1:0] act_int
);
    AST_TICK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (st != GEN_OFF)); // R1

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && act_int > INT_W'(1)) |=> !tick); // R2

    AST_ZERO_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (act_int == '0) |-> !tick); // R7

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st != GEN_OFF) |=> $stable(act_int)); // R6

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GEN_RUN && !uart_en && !busy) |=> (st == GEN_OFF)); // R8

    AST_DRAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GEN_RUN && !uart_en && busy) |=> (st == GEN_DRAIN)); // R9

    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GEN_DRAIN && !uart_en && !busy) |=> (st == GEN_OFF)); // R9

    AST_DRAIN_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GEN_DRAIN && uart_en) |=> (st == GEN_RUN)); // R10
endmodule

bind uart_frac_baud_gen baud_gen_checker #(.INT_W(INT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .uart_en (uart_en),
    .busy    (busy),
    .tick    (tick),
    .st      (st),
    .act_int (act_int)
);

// File: tb/tb_uart_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_int_wr = 1'b0;
    logic [15:0] div_int_data = '0;
    logic        div_frac_wr = 1'b0;
    logic [5:0]  div_frac_data = '0;
    logic        line_ctl_wr = 1'b0;
    logic        uart_en = 1'b0;
    logic        busy = 1'b0;
    logic        tick;

    uart_frac_baud_gen dut (
        .clk(clk), .rst_n(rst_n),
        .div_int_wr(div_int_wr), .div_int_data(div_int_data),
        .div_frac_wr(div_frac_wr), .div_frac_data(div_frac_data),
        .line_ctl_wr(line_ctl_wr), .uart_en(uart_en), .busy(busy),
        .tick(tick)
    );

    always #2.5 clk = ~clk;

    int    cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard: driver fills the expected-interval list, monitor consumes it
    int    exp_arr [0:127];
    int    exp_n = 0;
    int    epoch = 0;
    string cur_tag = "R2";

    int    exp_i = 0;
    int    seen_epoch = 0;
    int    prev_cyc = 0;
    bit    have_prev = 0;
    int    iv_sum = 0;
    int    tick_cnt = 0;
    int    mon_checks = 0;
    int    mon_fails = 0;

    int    checks = 0;
    int    fails = 0;

    always @(negedge clk) begin
        if (epoch != seen_epoch) begin
            seen_epoch = epoch;
            have_prev  = 0;
            exp_i      = 0;
            iv_sum     = 0;
        end
        if (rst_n && tick) begin
            if (have_prev && exp_i < exp_n) begin
                mon_checks++;
                iv_sum += cyc - prev_cyc;
                if ((cyc - prev_cyc) != exp_arr[exp_i]) begin
                    mon_fails++;
                    $display("FAIL %s interval %0d actual=%0d expected=%0d",
                             cur_tag, exp_i, cyc - prev_cyc, exp_arr[exp_i]);
                end
                exp_i++;
            end
            prev_cyc  = cyc;
            have_prev = 1;
            tick_cnt++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_int(input int v);
        div_int_data = 16'(v); div_int_wr = 1; step(1); div_int_wr = 0;
    endtask
    task automatic wr_frac(input int v);
        div_frac_data = 6'(v); div_frac_wr = 1; step(1); div_frac_wr = 0;
    endtask
    task automatic commit();
        line_ctl_wr = 1; step(1); line_ctl_wr = 0;
    endtask

    // independent model of the dithering sequence
    task automatic expect_run(input string tag, input int n, input int f, input int count);
        int acc = 0;
        int ext = 0;
        cur_tag = tag;
        for (int k = 0; k <= count; k++) begin
            int len = n + ext;
            acc = acc + f;
            ext = acc / 64;
            acc = acc % 64;
            if (k > 0) exp_arr[k-1] = len;
        end
        exp_n = count;
        epoch++;
        step(1);
    endtask

    task automatic sb_done(input string tag);
        check(tag, exp_i, exp_n);
    endtask

    initial begin
        int t0;
        step(4);
        rst_n = 1;
        step(20);
        check("R1 tick after reset", int'(tick), 0);
        check("R1 no ticks while idle", tick_cnt, 0);

        // R2: integer divisor only
        wr_int(10); wr_frac(0); commit();
        expect_run("R2", 10, 0, 20);
        uart_en = 1;
        step(230);
        sb_done("R2 intervals seen");

        // R8: disable with busy low
        uart_en = 0;
        step(2);
        t0 = tick_cnt;
        step(50);
        check("R8 ticks after disable", tick_cnt - t0, 0);

        // R3/R4: 10 + 54/64
        wr_int(10); wr_frac(54); commit();
        expect_run("R3", 10, 54, 64);
        uart_en = 1;
        step(66 * 11 + 20);
        sb_done("R3 intervals seen");
        check("R4 sum of 64 intervals", iv_sum, 694);
        uart_en = 0;
        step(3);

        // R5: staged writes are inert until committed
        wr_int(4); wr_frac(0);
        expect_run("R5 staged", 10, 54, 8);
        uart_en = 1;
        step(12 * 11);
        sb_done("R5 old divisor kept");
        uart_en = 0;
        step(3);
        commit();
        expect_run("R5 committed", 4, 0, 16);
        uart_en = 1;
        step(20);
        // R6: writes while running are discarded
        wr_int(7); commit();
        step(60);
        sb_done("R6 running write ignored");
        uart_en = 0;
        step(3);
        commit();
        expect_run("R6 stage unchanged", 4, 0, 10);
        uart_en = 1;
        step(60);
        sb_done("R6 stage unchanged");
        uart_en = 0;
        step(3);

        // R7: zero divisor
        wr_int(0); commit();
        expect_run("R7", 0, 0, 0);
        t0 = tick_cnt;
        uart_en = 1;
        step(100);
        check("R7 ticks with zero divisor", tick_cnt - t0, 0);
        uart_en = 0;
        step(3);

        // R9: drain while busy
        wr_int(6); wr_frac(0); commit();
        expect_run("R9", 6, 0, 0);
        busy = 1; uart_en = 1;
        step(30);
        uart_en = 0;
        step(5);
        t0 = tick_cnt;
        step(60);
        check("R9 ticks during drain", tick_cnt - t0, 10);
        busy = 0;
        step(3);
        t0 = tick_cnt;
        step(60);
        check("R9 ticks after busy falls", tick_cnt - t0, 0);

        // R10: re-enable during drain
        busy = 1; uart_en = 1;
        step(20);
        uart_en = 0;
        step(10);
        uart_en = 1;
        step(10);
        busy = 0;
        step(5);
        t0 = tick_cnt;
        step(60);
        check("R10 ticks after resume", tick_cnt - t0, 10);
        uart_en = 0;
        step(5);

        checks += mon_checks;
        fails  += mon_fails;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d",
                 checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end
endmodule